// File: doc/BRIEF.md
# Dual-Mode FIFO Full/Empty Status Logic

This block is the pointer and flag controller of a two-clock FIFO. It keeps the write and read pointers, exchanges them between the clock domains in Gray code through two-stage synchronisers, and drives the address and write strobe of an external storage array. It produces one status output on each side.

It runs in one of two modes, picked by a pin that is sampled while master reset is held. In standard mode the write-side output is an active-low full flag and the read-side output is an active-low empty flag. Read data appears in the output register on the read-clock edge that accepts the read.

In fall-through mode the write-side output is an active-low input-ready and the read-side output is an active-low output-ready. The controller moves the head word into the output register without waiting for a read request. That held word counts as stored, so one more write is accepted before the FIFO reports no room.

A partial reset empties the FIFO and keeps the selected mode.

Top module: `fifo_flag_ctrl`

## Requirements
- R1: After master reset in standard mode, `wr_flag`=1 and `rd_flag`=0. After master reset in fall-through mode, `wr_flag`=0 and `rd_flag`=1.
- R2: In standard mode, with no reads since reset, `wr_flag` stays 1 through the first D-1 writes and goes to 0 on the write-clock edge of the D-th write, where D = 2^ADDR_W. A write presented while it is 0 is not stored.
- R3: In fall-through mode, with no reads since reset and the first word already moved to the output register, `wr_flag` stays 0 through D writes and goes to 1 on the edge of write D+1. A write presented while it is 1 is not stored.
- R4: In standard mode, `rd_flag` rises on the third rising `rclk` edge after the `wclk` edge that writes into an empty FIFO. It falls on the edge of the read that takes the last word. A read presented while it is 0 leaves `dout` unchanged.
- R5: In fall-through mode, `rd_flag` falls on the fourth rising `rclk` edge after the `wclk` edge that writes into an empty FIFO. On that same edge `dout` shows the written word.
- R6: In fall-through mode, `rd_flag` stays 0 while a word is held and not read. It rises only on an `rclk` edge with `rd_en`=1 when no further word is available. `dout` then keeps the last word, and reads made while `rd_flag` is 1 change nothing.
- R7: Words leave in the order they were written, in both modes, with no loss and no duplication.
- R8: The mode is taken from `fwft_sel` only while `mrst_n` is low. A low pulse on `prst_n` empties the FIFO and restores the reset values of R1 for the mode already selected, whatever `fwft_sel` is at that time.
- R9: After a read frees a slot in a full FIFO, with no further writes, the write-side flag returns to its "room available" value within four `wclk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; the mode pin is sampled while it is low |
| prst_n | input | 1 | Partial reset, active low; clears pointers and flags only |
| fwft_sel | input | 1 | Mode pin: 1 selects fall-through, 0 selects standard |
| wr_en | input | 1 | Write request, `wclk` domain |
| rd_en | input | 1 | Read request, `rclk` domain |
| mem_rdata | input | DATA_W | Asynchronous read data from the storage array |
| mem_we | output | 1 | Storage write strobe |
| mem_waddr | output | ADDR_W | Storage write address |
| mem_raddr | output | ADDR_W | Storage read address |
| dout | output | DATA_W | Output data register |
| wr_flag | output | 1 | Full flag (standard) or input-ready (fall-through), both active low |
| rd_flag | output | 1 | Empty flag (standard) or output-ready (fall-through), both active low |

## Verification
The assertions assume the following about the inputs:
- `wr_en` and `rd_en` change only away from the rising edges of their own clocks.
- `fwft_sel` is steady for at least two edges of each clock before `mrst_n` rises.
- Each reset pulse covers at least two edges of both clocks.

With those assumptions, the mode register is checked as frozen, the pointers as frozen while the flags block traffic, and each Gray pointer as changing at most one bit per edge.

The stimulus meets these assumptions in the following way. It changes requests on falling clock edges. It sets the mode pin before master reset goes low and holds reset for three write cycles. It changes the mode pin only while a reset is active, or before a partial reset to show that the pin is ignored then.

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [DATA_W-1:0] dout,
  output logic              wr_flag,
  output logic              rd_flag
);
  localparam int PW = ADDR_W + 1;

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  // mode pin captured only under master reset, once per domain
  logic fwft_w, fwft_r;
  always_ff @(posedge wclk) if (!mrst_n) fwft_w <= fwft_sel;
  always_ff @(posedge rclk) if (!mrst_n) fwft_r <= fwft_sel;

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, rq1, rq2, wbin_nx, wgray_nx;
  logic          wfull, push;

  assign push     = wr_en & ~wfull;
  assign wbin_nx  = wbin + PW'(push);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
      wfull <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      rq1   <= rgray;
      rq2   <= rq1;
      wfull <= (wgray_nx == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    end
  end

  assign mem_we    = push;
  assign mem_waddr = wbin[ADDR_W-1:0];
  assign wr_flag   = fwft_w ? wfull : ~wfull;

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, wq1, wq2, rbin_nx, rgray_nx;
  logic          mem_has, ovalid, pop;

  assign pop      = mem_has & (fwft_r ? (~ovalid | rd_en) : rd_en);
  assign rbin_nx  = rbin + PW'(pop);
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wq1     <= '0;
      wq2     <= '0;
      mem_has <= 1'b0;
      ovalid  <= 1'b0;
      dout    <= '0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      wq1     <= wgray;
      wq2     <= wq1;
      mem_has <= (rgray_nx != wq2);
      ovalid  <= fwft_r & (pop | (ovalid & ~rd_en));
      if (pop) dout <= mem_rdata;
    end
  end

  assign mem_raddr = rbin[ADDR_W-1:0];
  assign rd_flag   = fwft_r ? ~ovalid : mem_has;

  // ---------------- assertions ----------------
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    wfull |=> $stable(wbin));

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    !mem_has |=> $stable(rbin));

  p_held_word_kept_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_r && ovalid && !rd_en) |=> (ovalid && $stable(dout)));

  p_ready_drop_needs_read_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(ovalid) |-> $past(rd_en));

  p_wgray_step_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_rgray_step_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  p_mode_frozen_r8: assert property (@(posedge rclk) disable iff (!mrst_n)
    $stable(fwft_r));

endmodule

// File: tb/fifo_flag_ctrl_bench.sv
module fifo_flag_ctrl_bench;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int D  = 1 << AW;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, fwft_sel = 0, wr_en = 0, rd_en = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] mem_rdata, dout;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic mem_we, wr_flag, rd_flag;

  initial forever #2 wclk = ~wclk;
  initial begin #1; forever #2 rclk = ~rclk; end

  logic [DW-1:0] ram [D];
  initial for (int i = 0; i < D; i++) ram[i] = '0;
  always @(posedge wclk) if (mem_we) ram[mem_waddr] <= wdata;
  assign mem_rdata = ram[mem_raddr];

  fifo_flag_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_fifo_flag_ctrl (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .rd_en(rd_en), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_raddr(mem_raddr), .dout(dout),
    .wr_flag(wr_flag), .rd_flag(rd_flag));

  int n_chk = 0, n_fail = 0;
  bit fwft_mode = 0;
  logic last_wflag;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor (R7)
  task automatic sb_pop(input logic [DW-1:0] act);
    if (exp_q.size() == 0) chk(0, "R7 unexpected word", act, -1);
    else begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk(act == e, "R7 order", act, e);
    end
  endtask

  always @(posedge rclk) begin
    if (rd_en && mrst_n && prst_n) begin
      if (fwft_mode && !rd_flag) sb_pop(dout);
      else if (!fwft_mode && rd_flag) begin #1; sb_pop(dout); end
    end
  end

  // driver: write then two idle write cycles
  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1; wdata = d;
    if (fwft_mode ? !wr_flag : wr_flag) exp_q.push_back(d);
    @(negedge wclk);
    wr_en = 0;
    last_wflag = wr_flag;
    repeat (2) @(negedge wclk);
  endtask

  task automatic rd();
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic do_mrst(input bit m);
    @(negedge wclk);
    fwft_sel = m; fwft_mode = m; mrst_n = 0;
    repeat (3) @(negedge wclk);
    mrst_n = 1; exp_q.delete();
    repeat (3) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic do_prst(input bit pin);
    @(negedge wclk);
    fwft_sel = pin; prst_n = 0;
    repeat (3) @(negedge wclk);
    prst_n = 1; exp_q.delete();
    repeat (3) @(negedge wclk);
    @(negedge rclk);
  endtask

  initial begin
    #100000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // ---------- standard mode ----------
    do_mrst(0);
    chk(wr_flag == 1, "R1 std full flag", wr_flag, 1);
    chk(rd_flag == 0, "R1 std empty flag", rd_flag, 0);

    // R4 empty-flag latency
    @(negedge wclk); wr_en = 1; wdata = 8'h11; exp_q.push_back(8'h11);
    @(posedge wclk);
    @(negedge wclk); wr_en = 0;
    @(negedge rclk);
    @(negedge rclk);
    chk(rd_flag == 0, "R4 empty after 2 rclk", rd_flag, 0);
    @(negedge rclk);
    chk(rd_flag == 1, "R4 not empty after 3 rclk", rd_flag, 1);

    // R2 full count
    for (int k = 2; k <= D; k++) begin
      wr(DW'(8'h10 + k));
      if (k == D - 1) chk(last_wflag == 1, "R2 not full at D-1", last_wflag, 1);
      if (k == D)     chk(last_wflag == 0, "R2 full at D", last_wflag, 0);
    end
    wr(8'hEE);
    chk(last_wflag == 0, "R2 still full", last_wflag, 0);

    for (int k = 1; k <= D; k++) begin
      rd();
      if (k == D - 1) chk(rd_flag == 1, "R4 one word left", rd_flag, 1);
      if (k == D)     chk(rd_flag == 0, "R4 empty on last read", rd_flag, 0);
    end
    rd();
    chk(dout == DW'(8'h10 + D), "R4 read while empty", dout, 8'h10 + D);
    chk(exp_q.size() == 0, "R2 blocked write absent", exp_q.size(), 0);

    // R9 recovery in standard mode
    for (int k = 0; k < D; k++) wr(DW'(8'h40 + k));
    chk(wr_flag == 0, "R9 std full", wr_flag, 0);
    rd();
    repeat (4) @(negedge wclk);
    chk(wr_flag == 1, "R9 std room again", wr_flag, 1);

    // R8 partial reset keeps standard mode despite pin
    do_prst(1);
    chk(wr_flag == 1, "R8 prst keeps std (wr)", wr_flag, 1);
    chk(rd_flag == 0, "R8 prst keeps std (rd)", rd_flag, 0);

    // ---------- fall-through mode ----------
    do_mrst(1);
    chk(wr_flag == 0, "R1 fwft input ready", wr_flag, 0);
    chk(rd_flag == 1, "R1 fwft output not ready", rd_flag, 1);

    // R5 output-ready latency
    @(negedge wclk); wr_en = 1; wdata = 8'h21; exp_q.push_back(8'h21);
    @(posedge wclk);
    @(negedge wclk); wr_en = 0;
    repeat (3) @(negedge rclk);
    chk(rd_flag == 1, "R5 not ready after 3 rclk", rd_flag, 1);
    @(negedge rclk);
    chk(rd_flag == 0, "R5 ready after 4 rclk", rd_flag, 0);
    chk(dout == 8'h21, "R5 word on outputs", dout, 8'h21);

    // R6 held word, true read, last word stays
    repeat (5) @(negedge rclk);
    chk(rd_flag == 0, "R6 stays ready without read", rd_flag, 0);
    rd();
    chk(rd_flag == 1, "R6 not ready after last read", rd_flag, 1);
    chk(dout == 8'h21, "R6 last word kept", dout, 8'h21);
    rd();
    chk(dout == 8'h21, "R6 read while not ready", dout, 8'h21);
    chk(exp_q.size() == 0, "R6 no extra word", exp_q.size(), 0);

    // R3 input-ready count
    for (int k = 1; k <= D + 1; k++) begin
      wr(DW'(8'h30 + k));
      if (k == D)     chk(last_wflag == 0, "R3 ready at D", last_wflag, 0);
      if (k == D + 1) chk(last_wflag == 1, "R3 not ready at D+1", last_wflag, 1);
    end
    wr(8'hEE);
    chk(last_wflag == 1, "R3 still not ready", last_wflag, 1);

    rd();
    repeat (4) @(negedge wclk);
    chk(wr_flag == 0, "R9 fwft ready again", wr_flag, 0);
    for (int k = 2; k <= D + 1; k++) rd();
    chk(rd_flag == 1, "R6 drained", rd_flag, 1);
    chk(dout == DW'(8'h30 + D + 1), "R3 last accepted word", dout, 8'h30 + D + 1);
    chk(exp_q.size() == 0, "R7 all words read", exp_q.size(), 0);

    // R8 partial reset keeps fall-through mode
    wr(8'h55);
    do_prst(0);
    chk(wr_flag == 0, "R8 prst keeps fwft (wr)", wr_flag, 0);
    chk(rd_flag == 1, "R8 prst keeps fwft (rd)", rd_flag, 1);

    finish_run();
  end
endmodule